// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Writer

This block is the receive half of an Ethernet MAC's DMA engine. Software places a ring of eight-byte descriptors in memory: a buffer address word followed by a status word. Bit 0 of the address word is the ownership flag and bit 1 is the end-of-ring flag. The engine walks this ring from a programmable base. Each received frame goes into the buffer of the current free descriptor. The engine then writes the length and flags into the status word and hands the descriptor back to software by setting the ownership flag.

Frame data arrives as a stream of 32-bit words with no backpressure. The engine writes memory through a zero-wait-state word port. Frame data is sent as two-word bursts wherever the address allows. The engine gets a free descriptor ready between frames. A frame that starts while no free descriptor is ready is discarded and raises a sticky overrun flag. Every stored frame occupies exactly one buffer. Any bytes past the end of the buffer are thrown away, and the descriptor is marked truncated.

Top module: `rx_ring_dma`

## Requirements
- R1: The engine reads the address word of the current descriptor. It stores a frame only into a descriptor whose bit 0 (ownership) reads 0. While that bit reads 1, it keeps re-reading the same descriptor, and any frame that starts in that time is not stored.
- R2: Frame words go, unchanged, into consecutive word addresses. The first word goes to the buffer address, which is the address word with its two low bits cleared.
- R3: After the frame data, the engine writes the status word at descriptor+4. Its fields are [13:0] stored length in bytes, bit 14 start-of-frame = 1, bit 15 end-of-frame = 1, and bit 16 truncated. Only after that does it rewrite the address word with bit 0 set and all other bits kept.
- R4: Descriptors lie 8 bytes apart, so the next descriptor is at +8. After a descriptor whose bit 1 (end-of-ring) was set, the engine returns to the base address, with its low three bits ignored.
- R5: The buffer holds cfg_bufsz × 64 bytes, and a setting of 0 acts as 1. If a frame is longer, only the first buffer-size bytes are written, the length field equals the buffer size, and bit 16 is set. Nothing is written past the buffer.
- R6: The length equals 4 × (words − 1) plus the byte count of the last word. That count is in_bytes on the last word, where 0 means 4.
- R7: A frame that starts while enabled but with no free descriptor ready causes no memory write and sets stat_ovr. stat_ovr stays set until a clr_ovr pulse.
- R8: stat_done becomes 1 when a descriptor is handed back. It stays set until a clr_done pulse.
- R9: mem_burst marks the first beat of a two-word write. The second beat follows in the next cycle at address+4. No burst starts on the last word of a 1 KB region.
- R10: Driving cfg_enable low abandons any frame in progress and returns the descriptor pointer to the base. Frames that arrive while disabled are discarded without setting stat_ovr.
- R11: After reset, mem_req, stat_done and stat_ovr are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Receive enable |
| cfg_base | input | 32 | Byte address of the first descriptor |
| cfg_bufsz | input | 8 | Buffer size in 64-byte units |
| clr_done | input | 1 | Clears stat_done |
| clr_ovr | input | 1 | Clears stat_ovr |
| stat_done | output | 1 | Sticky receive-complete flag |
| stat_ovr | output | 1 | Sticky overrun flag |
| in_valid | input | 1 | Frame word present |
| in_data | input | 32 | Frame word |
| in_last | input | 1 | Last word of the frame |
| in_bytes | input | 2 | Valid bytes in the last word, 0 meaning 4 |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_burst | output | 1 | First beat of a two-word write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the same cycle |

## Verification
A wrong descriptor pointer or a stale end-of-ring flag sends the next frame to the wrong descriptor. This is visible in memory within a few cycles of that frame's last word, as a status word that appears somewhere other than expected. A miscounted word index shows up as a wrong length field or as a sentinel beyond the buffer being overwritten. A lost held word in the burst packer leaves a gap in the buffer. A wrong ownership decision appears either as writes during a frame that should have been dropped or as no handoff at all. Each frame is therefore checked against its descriptor words, its buffer contents and the write count, a dozen cycles after it ends.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;

    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 32;
    localparam int BSZ_W   = 8;
    localparam int WCNT_W  = BSZ_W + 4;   // words per buffer
    localparam int LEN_W   = WCNT_W + 2;  // bytes per buffer

    // descriptor bit positions (software decodes these)
    localparam int OWN_BIT   = 0;
    localparam int WRAP_BIT  = 1;
    localparam int SOF_BIT   = LEN_W;
    localparam int EOF_BIT   = LEN_W + 1;
    localparam int TRUNC_BIT = LEN_W + 2;

    localparam int KB_WORD_LO = 2;
    localparam int KB_WORD_HI = 9;

    typedef enum logic [2:0] {
        ST_OFF, ST_FETCH, ST_READY, ST_RECV, ST_FLUSH, ST_WSTAT, ST_WOWN
    } walk_st_e;

    typedef struct packed {
        logic              v;
        logic [ADDR_W-1:0] a;
        logic [DATA_W-1:0] d;
    } beat_t;

    typedef struct packed {
        logic              req;
        logic              we;
        logic              burst;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } mem_cmd_t;

    function automatic logic [WCNT_W-1:0] cap_words(input logic [BSZ_W-1:0] bsz);
        logic [BSZ_W-1:0] eff;
        eff = (bsz == '0) ? BSZ_W'(1) : bsz;
        return {eff, 4'b0000};
    endfunction

    function automatic logic [2:0] tail_bytes(input logic [1:0] b);
        return (b == 2'd0) ? 3'd4 : {1'b0, b};
    endfunction

    function automatic logic at_kb_edge(input logic [ADDR_W-1:0] a);
        return &a[KB_WORD_HI:KB_WORD_LO];
    endfunction

endpackage

// File: rtl/rx_ring_packer.sv
module rx_ring_packer
    import rx_ring_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              abort,
    input  logic              flush,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    output mem_cmd_t          cmd,
    output logic              idle
);

    beat_t pend_q, pend_d, b2_q, b2_d, in_b;

    always_comb begin
        in_b.v = st_valid;
        in_b.a = st_addr;
        in_b.d = st_data;
    end

    always_comb begin
        cmd    = '0;
        pend_d = pend_q;
        b2_d   = b2_q;
        if (abort) begin
            pend_d = '0;
            b2_d   = '0;
        end else if (b2_q.v) begin
            cmd.req  = 1'b1;
            cmd.we   = 1'b1;
            cmd.addr = b2_q.a;
            cmd.data = b2_q.d;
            b2_d.v   = 1'b0;
            if (st_valid) pend_d = in_b;
        end else if (pend_q.v) begin
            if (at_kb_edge(pend_q.a) || flush) begin
                cmd.req  = 1'b1;
                cmd.we   = 1'b1;
                cmd.addr = pend_q.a;
                cmd.data = pend_q.d;
                pend_d   = in_b;
            end else if (st_valid) begin
                cmd.req   = 1'b1;
                cmd.we    = 1'b1;
                cmd.burst = 1'b1;
                cmd.addr  = pend_q.a;
                cmd.data  = pend_q.d;
                b2_d      = in_b;
                pend_d.v  = 1'b0;
            end
        end else if (st_valid) begin
            if (at_kb_edge(st_addr)) begin
                cmd.req  = 1'b1;
                cmd.we   = 1'b1;
                cmd.addr = st_addr;
                cmd.data = st_data;
            end else begin
                pend_d = in_b;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            b2_q   <= '0;
        end else begin
            pend_q <= pend_d;
            b2_q   <= b2_d;
        end
    end

    assign idle = !pend_q.v && !b2_q.v;

    // R9
    burst_edge_chk: assert property (@(posedge clk) disable iff (rst)
        cmd.burst |-> !at_kb_edge(cmd.addr));

    // R9
    burst_pair_chk: assert property (@(posedge clk) disable iff (rst || abort)
        cmd.burst |=> (cmd.req && cmd.we && !cmd.burst
                       && cmd.addr == $past(cmd.addr) + ADDR_W'(4)));

endmodule

// File: rtl/rx_ring_walker.sv
module rx_ring_walker
    import rx_ring_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [ADDR_W-1:0] base,
    input  logic [BSZ_W-1:0]  bufsz,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic [1:0]        in_bytes,
    input  logic [DATA_W-1:0] rdata,
    input  logic              pk_idle,
    output mem_cmd_t          d_cmd,
    output logic              st_valid,
    output logic [ADDR_W-1:0] st_addr,
    output logic              flush,
    output logic              abort,
    output logic              evt_done,
    output logic              evt_ovr
);

    localparam logic [ADDR_W-1:0] DESC_MASK = ~ADDR_W'(7);
    localparam logic [ADDR_W-1:0] BUF_MASK  = ~ADDR_W'(3);

    walk_st_e          state;
    logic [ADDR_W-1:0] ptr, buf_a, base_al;
    logic              wrap_q, trunc_q, in_frame;
    logic [WCNT_W-1:0] wcnt, capw;
    logic [LEN_W-1:0]  len_q, len_fit;
    logic              start, take, room;
    logic [DATA_W-1:0] stat_word;

    always_comb begin
        base_al  = base & DESC_MASK;
        capw     = cap_words(bufsz);
        start    = in_valid && !in_frame;
        take     = (state == ST_READY && start) || (state == ST_RECV && in_valid);
        room     = wcnt < capw;
        st_valid = take && room;
        st_addr  = buf_a + {{(ADDR_W-WCNT_W-2){1'b0}}, wcnt, 2'b00};
        len_fit  = {wcnt, 2'b00} + LEN_W'(tail_bytes(in_bytes));
        flush    = state == ST_FLUSH;
        abort    = !enable;
        evt_done = enable && state == ST_WOWN;
        evt_ovr  = enable && start && state != ST_READY;

        stat_word            = '0;
        stat_word[LEN_W-1:0] = len_q;
        stat_word[SOF_BIT]   = 1'b1;
        stat_word[EOF_BIT]   = 1'b1;
        stat_word[TRUNC_BIT] = trunc_q;

        d_cmd = '0;
        case (state)
            ST_FETCH: begin
                d_cmd.req  = enable;
                d_cmd.addr = ptr;
            end
            ST_WSTAT: begin
                d_cmd.req  = enable;
                d_cmd.we   = 1'b1;
                d_cmd.addr = ptr + ADDR_W'(4);
                d_cmd.data = stat_word;
            end
            ST_WOWN: begin
                d_cmd.req  = enable;
                d_cmd.we   = 1'b1;
                d_cmd.addr = ptr;
                d_cmd.data = buf_a;
                d_cmd.data[WRAP_BIT] = wrap_q;
                d_cmd.data[OWN_BIT]  = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_OFF;
            ptr      <= '0;
            buf_a    <= '0;
            wrap_q   <= 1'b0;
            trunc_q  <= 1'b0;
            wcnt     <= '0;
            len_q    <= '0;
            in_frame <= 1'b0;
        end else begin
            if (in_valid) in_frame <= !in_last;
            if (!enable) begin
                state <= ST_OFF;
                ptr   <= base_al;
            end else begin
                case (state)
                    ST_OFF: begin
                        ptr   <= base_al;
                        state <= ST_FETCH;
                    end
                    ST_FETCH: begin
                        wcnt    <= '0;
                        trunc_q <= 1'b0;
                        if (!rdata[OWN_BIT]) begin
                            buf_a  <= rdata & BUF_MASK;
                            wrap_q <= rdata[WRAP_BIT];
                            state  <= ST_READY;
                        end
                    end
                    ST_READY, ST_RECV: begin
                        if (take) begin
                            if (room) wcnt <= wcnt + WCNT_W'(1);
                            if (in_last) begin
                                len_q   <= room ? len_fit : {capw, 2'b00};
                                trunc_q <= !room;
                                state   <= ST_FLUSH;
                            end else begin
                                state <= ST_RECV;
                            end
                        end
                    end
                    ST_FLUSH: if (pk_idle) state <= ST_WSTAT;
                    ST_WSTAT: state <= ST_WOWN;
                    ST_WOWN: begin
                        ptr   <= wrap_q ? base_al : ptr + ADDR_W'(8);
                        state <= ST_FETCH;
                    end
                    default: state <= ST_OFF;
                endcase
            end
        end
    end

    // R3
    handoff_order_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WOWN) |-> ($past(state) == ST_WSTAT));

    // R1
    owned_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH && rdata[OWN_BIT]) |=> (state != ST_READY));

    // R10
    disable_home_chk: assert property (@(posedge clk) disable iff (rst)
        (!enable) |=> (state == ST_OFF && ptr == $past(base_al)));

    // R5
    store_room_chk: assert property (@(posedge clk) disable iff (rst)
        st_valid |-> (wcnt < capw));

endmodule

// File: rtl/rx_ring_flags.sv
module rx_ring_flags (
    input  logic clk,
    input  logic rst,
    input  logic evt_done,
    input  logic evt_ovr,
    input  logic clr_done,
    input  logic clr_ovr,
    output logic done_q,
    output logic ovr_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            done_q <= evt_done | (done_q & ~clr_done);
            ovr_q  <= evt_ovr  | (ovr_q  & ~clr_ovr);
        end
    end

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done_q && !clr_done) |=> done_q);

    // R7
    ovr_raise_chk: assert property (@(posedge clk) disable iff (rst)
        evt_ovr |=> ovr_q);

endmodule

// File: rtl/rx_ring_dma.sv
module rx_ring_dma
    import rx_ring_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_enable,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [BSZ_W-1:0]  cfg_bufsz,
    input  logic              clr_done,
    input  logic              clr_ovr,
    output logic              stat_done,
    output logic              stat_ovr,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    input  logic [1:0]        in_bytes,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_burst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    mem_cmd_t          d_cmd, pk_cmd, sel_cmd;
    logic              st_valid, flush, abort, pk_idle, evt_done, evt_ovr;
    logic [ADDR_W-1:0] st_addr;

    rx_ring_walker u_walker (
        .clk      (clk),
        .rst      (rst),
        .enable   (cfg_enable),
        .base     (cfg_base),
        .bufsz    (cfg_bufsz),
        .in_valid (in_valid),
        .in_last  (in_last),
        .in_bytes (in_bytes),
        .rdata    (mem_rdata),
        .pk_idle  (pk_idle),
        .d_cmd    (d_cmd),
        .st_valid (st_valid),
        .st_addr  (st_addr),
        .flush    (flush),
        .abort    (abort),
        .evt_done (evt_done),
        .evt_ovr  (evt_ovr)
    );

    rx_ring_packer u_packer (
        .clk      (clk),
        .rst      (rst),
        .abort    (abort),
        .flush    (flush),
        .st_valid (st_valid),
        .st_addr  (st_addr),
        .st_data  (in_data),
        .cmd      (pk_cmd),
        .idle     (pk_idle)
    );

    rx_ring_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .evt_done (evt_done),
        .evt_ovr  (evt_ovr),
        .clr_done (clr_done),
        .clr_ovr  (clr_ovr),
        .done_q   (stat_done),
        .ovr_q    (stat_ovr)
    );

    assign sel_cmd   = pk_cmd.req ? pk_cmd : d_cmd;
    assign mem_req   = sel_cmd.req;
    assign mem_we    = sel_cmd.we;
    assign mem_burst = sel_cmd.burst;
    assign mem_addr  = sel_cmd.addr;
    assign mem_wdata = sel_cmd.data;

    // R1
    port_share_chk: assert property (@(posedge clk) disable iff (rst)
        !(pk_cmd.req && d_cmd.req));

    // R11
    quiet_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_enable) |=> !mem_req);

endmodule

// File: tb/rx_ring_dma_bench.sv
`timescale 1ns/1ps
module rx_ring_dma_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_enable = 1'b0;
    logic [31:0] cfg_base = 32'h100;
    logic [7:0]  cfg_bufsz = 8'h18;
    logic        clr_done = 1'b0, clr_ovr = 1'b0;
    logic        stat_done, stat_ovr;
    logic        in_valid = 1'b0, in_last = 1'b0;
    logic [31:0] in_data = '0;
    logic [1:0]  in_bytes = '0;
    logic        mem_req, mem_we, mem_burst;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    logic        h_we = 1'b0;
    logic [31:0] h_addr = '0, h_data = '0;
    logic [31:0] mem [0:4095];
    int          wr_count = 0;
    int          n_burst = 0, n_bad = 0;
    int          checks = 0, errors = 0;

    always #4 clk = ~clk;

    rx_ring_dma u_rx_ring_dma (
        .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_base(cfg_base),
        .cfg_bufsz(cfg_bufsz), .clr_done(clr_done), .clr_ovr(clr_ovr),
        .stat_done(stat_done), .stat_ovr(stat_ovr), .in_valid(in_valid),
        .in_data(in_data), .in_last(in_last), .in_bytes(in_bytes),
        .mem_req(mem_req), .mem_we(mem_we), .mem_burst(mem_burst),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    assign mem_rdata = mem[mem_addr[13:2]];

    always @(posedge clk) begin
        if (h_we) mem[h_addr[13:2]] <= h_data;
        else if (mem_req && mem_we) begin
            mem[mem_addr[13:2]] <= mem_wdata;
            wr_count <= wr_count + 1;
        end
    end

    always @(negedge clk) begin
        if (!rst && mem_req && mem_burst) begin
            n_burst = n_burst + 1;
            if (mem_addr[9:2] == 8'hFF) n_bad = n_bad + 1;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_wr(logic [31:0] a, logic [31:0] d);
        @(negedge clk);
        h_we = 1'b1; h_addr = a; h_data = d;
        @(negedge clk);
        h_we = 1'b0;
    endtask

    task automatic send_frame(int n, logic [1:0] lb, logic [15:0] seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = {seed, 16'(i)};
            in_last  = (i == n - 1);
            in_bytes = (i == n - 1) ? lb : 2'd0;
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; in_bytes = 2'd0;
        repeat (12) @(negedge clk);
    endtask

    task automatic check_frame(string tag, logic [31:0] desc, logic [31:0] bufa,
                               int nw, logic [15:0] seed,
                               logic [31:0] exp_stat, logic [31:0] exp_addr);
        for (int i = 0; i < nw; i++)
            check({tag, " R2 data"}, mem[(bufa[13:2]) + 12'(i)], {seed, 16'(i)});
        check({tag, " R3 status word"}, mem[desc[13:2] + 12'd1], exp_stat);
        check({tag, " R3 handoff word"}, mem[desc[13:2]], exp_addr);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 mem_req", {31'b0, mem_req}, 32'd0);
        check("R11 stat_done", {31'b0, stat_done}, 32'd0);
        check("R11 stat_ovr", {31'b0, stat_ovr}, 32'd0);
    endtask

    task automatic t_basic();
        cfg_enable = 1'b1;
        repeat (5) @(negedge clk);
        send_frame(5, 2'd2, 16'hA100);
        check_frame("R6 five words", 32'h100, 32'h1000, 5, 16'hA100, 32'h0000C012, 32'h00001001);
        check("R8 done set", {31'b0, stat_done}, 32'd1);
        check("R9 burst count", 32'(n_burst), 32'd2);
        @(negedge clk); clr_done = 1'b1;
        @(negedge clk); clr_done = 1'b0;
        @(negedge clk);
        check("R8 done cleared", {31'b0, stat_done}, 32'd0);
    endtask

    task automatic t_edge();
        send_frame(6, 2'd0, 16'hB200);
        check_frame("R9 kb edge", 32'h108, 32'h23F4, 6, 16'hB200, 32'h0000C018, 32'h000023F5);
        check("R9 no burst on kb edge", 32'(n_bad), 32'd0);
        check("R9 burst count", 32'(n_burst), 32'd4);
    endtask

    task automatic t_wrap_and_overrun();
        int wr0;
        send_frame(3, 2'd3, 16'hC300);
        check_frame("R4 last desc", 32'h110, 32'h3000, 3, 16'hC300, 32'h0000C00B, 32'h00003003);
        wr0 = wr_count;
        send_frame(4, 2'd0, 16'hD400);
        check("R7 dropped frame no writes", 32'(wr_count), 32'(wr0));
        check("R1 owned desc untouched", mem[12'h41], 32'h0000C012);
        check("R7 overrun set", {31'b0, stat_ovr}, 32'd1);
        @(negedge clk); clr_ovr = 1'b1;
        @(negedge clk); clr_ovr = 1'b0;
        @(negedge clk);
        check("R7 overrun cleared", {31'b0, stat_ovr}, 32'd0);
        host_wr(32'h100, 32'h00001000);
        repeat (4) @(negedge clk);
        send_frame(8, 2'd1, 16'hE500);
        check_frame("R4 wrapped to base", 32'h100, 32'h1000, 8, 16'hE500, 32'h0000C01D, 32'h00001001);
    endtask

    task automatic t_trunc();
        cfg_enable = 1'b0;
        host_wr(32'h100, 32'h00001000);
        host_wr(32'h104, 32'h0);
        host_wr(32'h108, 32'h00002000);
        host_wr(32'h10C, 32'h0);
        host_wr(32'h1040, 32'hDEADBEEF);
        cfg_bufsz = 8'h01;
        @(negedge clk);
        cfg_enable = 1'b1;
        repeat (5) @(negedge clk);
        send_frame(20, 2'd2, 16'hF600);
        check_frame("R5 R10 truncated into base", 32'h100, 32'h1000, 16, 16'hF600,
                    32'h0001C040, 32'h00001001);
        check("R5 sentinel past buffer", mem[12'h410], 32'hDEADBEEF);
        check("R10 second desc untouched", mem[12'h43], 32'h0);
    endtask

    task automatic t_disabled_and_short();
        int wr0;
        cfg_enable = 1'b0;
        @(negedge clk);
        wr0 = wr_count;
        send_frame(3, 2'd0, 16'h1700);
        check("R10 disabled no writes", 32'(wr_count), 32'(wr0));
        check("R10 disabled no overrun", {31'b0, stat_ovr}, 32'd0);
        host_wr(32'h100, 32'h00001000);
        cfg_bufsz = 8'h18;
        @(negedge clk);
        cfg_enable = 1'b1;
        repeat (5) @(negedge clk);
        send_frame(1, 2'd3, 16'h2800);
        check_frame("R6 single word", 32'h100, 32'h1000, 1, 16'h2800, 32'h0000C003, 32'h00001001);
    endtask

    initial begin
        host_wr(32'h100, 32'h00001000);
        host_wr(32'h108, 32'h000023F4);
        host_wr(32'h110, 32'h00003002);
        t_reset();
        t_basic();
        t_edge();
        t_wrap_and_overrun();
        t_trunc();
        t_disabled_and_short();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R11 actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule